// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block places incoming frames into a ring of receive descriptors that sit in a shared byte-wide synchronous memory. A frame arrives as a byte stream with valid/ready handshaking and first/last markers. When the first byte of a frame is presented, the engine holds the stream off and scans the ring for a descriptor that the controller owns. The scan starts at the current receive pointer and wraps around the ring. The engine then accepts the frame bytes and writes them into the buffer slot tied to that descriptor. After the last byte it writes back the received length and marks the descriptor complete, which returns it to the host. Last, it advances the receive pointer and raises the receive interrupt flags.

Each descriptor is eight bytes at `ring_base + 8*i`. The buffers follow the ring, so slot `i` starts at `ring_base + 8*RING + i*SLOT_BYTES`. The engine reads and writes only the status byte (offset 2) and the two message-length bytes (offsets 6 and 7). If no descriptor qualifies, the frame is consumed and discarded and a missed-frame pulse is emitted. Dropping `run` stops the engine and clears its flags.

Top module: `rxr_engine`

## Requirements
- R1: After reset, `rx_ptr` is 0 and `rx_int`, `int_any` and `miss_pulse` are all 0.
- R2: While `run` is 0, `in_ready` is 0, no memory access is made, and one cycle later `rx_int` and `int_any` are both 0.
- R3: A descriptor qualifies only when its status byte (offset 2) equals exactly 8'h80. The values 8'h81, 8'hC0 and 8'h00 are skipped and left unchanged.
- R4: The scan checks descriptors `rx_ptr`, `rx_ptr+1`, ... modulo RING, and picks the first one that qualifies.
- R5: Frame byte n is written to `ring_base + 8*RING + slot*SLOT_BYTES + n`, for n < SLOT_BYTES.
- R6: The message length, min(frame bytes, SLOT_BYTES), is stored as a positive count with the high byte at descriptor offset 6 and the low byte at offset 7.
- R7: On completion the status byte becomes 8'h03. If the frame was longer than SLOT_BYTES it becomes 8'h13 (overflow bit 4 set), and bytes past the slot are not written.
- R8: After each delivered frame, `rx_ptr` advances by exactly one modulo RING, whichever slot was used.
- R9: After a delivered frame, `rx_int` and `int_any` are 1 and stay 1 while `run` remains 1.
- R10: If no descriptor qualifies, the frame is consumed with no memory write and `rx_ptr` is unchanged. `miss_pulse` is high for exactly one cycle, `int_any` becomes 1 and `rx_int` does not change.
- R11: `in_ready` is 0 while the engine scans (including when a first byte waits in idle) and during the three write-back cycles after a last byte.
- R12: Descriptor bytes at offsets 0, 1, 3, 4 and 5 are never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | 1 = engine running, 0 = stopped |
| ring_base | input | ADDR_W | Byte address of descriptor 0 |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_first | input | 1 | Byte is the first of a frame |
| in_last | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Engine accepts the byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| rx_ptr | output | IDX_W | Current receive pointer |
| rx_int | output | 1 | Receive interrupt flag |
| int_any | output | 1 | Interrupt summary: a frame was delivered or missed |
| miss_pulse | output | 1 | One-cycle pulse when a frame finds no descriptor |

## Verification
The assertions assume the memory returns read data exactly one cycle after a read request. They also assume that nothing else writes the descriptor status byte while a scan or a frame is in progress. The bench honours both: its memory model registers read data on the request edge, and it rewrites descriptor status bytes only when the stream is idle and every write-back has finished. The assertions also take `run` as held steady across each frame, and the bench toggles it only between frames.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_CHK, ST_RECV, ST_DROP, ST_WLH, ST_WLL, ST_WST
  } rx_state_t;

  localparam logic [7:0] STAT_OWNED = 8'h80;
  localparam logic [7:0] STAT_DONE  = 8'h03;
  localparam logic [7:0] STAT_OVF   = 8'h10;
  localparam int DESC_BYTES = 8;
  localparam int OFF_STAT   = 2;
  localparam int OFF_LEN_HI = 6;
  localparam int OFF_LEN_LO = 7;

  // byte address of one field of descriptor idx
  function automatic logic [31:0] desc_byte(logic [31:0] base, logic [31:0] idx,
                                            logic [31:0] off);
    return base + idx * DESC_BYTES + off;
  endfunction

  // byte address of byte n of buffer slot idx; buffers follow the ring
  function automatic logic [31:0] buf_byte(logic [31:0] base, logic [31:0] ring,
                                           logic [31:0] slot_bytes, logic [31:0] idx,
                                           logic [31:0] n);
    return base + ring * DESC_BYTES + idx * slot_bytes + n;
  endfunction

  // stored length: count capped at the slot size
  function automatic logic [31:0] cap_len(logic [31:0] cnt, logic [31:0] slot_bytes);
    return (cnt > slot_bytes) ? slot_bytes : cnt;
  endfunction

  function automatic logic [7:0] done_stat(logic ovf);
    return ovf ? (STAT_DONE | STAT_OVF) : STAT_DONE;
  endfunction

endpackage

// File: rtl/rxr_ring_idx.sv
module rxr_ring_idx #(
  parameter int RING = 16,
  localparam int IDX_W = $clog2(RING)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_clr,
  input  logic             scan_step,
  input  logic             advance,
  output logic [IDX_W-1:0] rx_ptr,
  output logic [IDX_W-1:0] scan_idx,
  output logic             scan_last
);

  logic [IDX_W:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ptr <= '0;
      off_q  <= '0;
    end else begin
      if (advance) rx_ptr <= IDX_W'((32'(rx_ptr) + 32'd1) % RING);
      if (scan_clr) off_q <= '0;
      else if (scan_step) off_q <= off_q + 1'b1;
    end
  end

  assign scan_idx  = IDX_W'((32'(rx_ptr) + 32'(off_q)) % RING);
  assign scan_last = (32'(off_q) == RING - 1);

  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (32'(rx_ptr) == (32'($past(rx_ptr)) + 32'd1) % RING));

  assert_scan_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    scan_step |-> !scan_last);

endmodule

// File: rtl/rxr_fill.sv
module rxr_fill #(
  parameter int CNT_W      = 16,
  parameter int SLOT_BYTES = 1544
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  output logic [CNT_W-1:0] count,
  output logic             room,
  output logic             ovf,
  output logic [15:0]      len
);

  import rxr_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (clr) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (take) begin
      if (!room) ovf <= 1'b1;
      if (count != '1) count <= count + 1'b1;
    end
  end

  assign room = (32'(count) < SLOT_BYTES);
  assign len  = 16'(cap_len(32'(count), SLOT_BYTES));

  assert_ovf_trunc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !room && !clr) |=> ovf);

endmodule

// File: rtl/rxr_flags.sv
module rxr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic done,
  input  logic miss,
  output logic rx_int,
  output logic int_any
);

  logic miss_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_int    <= 1'b0;
      miss_seen <= 1'b0;
    end else if (!run) begin
      rx_int    <= 1'b0;
      miss_seen <= 1'b0;
    end else begin
      if (done) rx_int <= 1'b1;
      if (miss) miss_seen <= 1'b1;
    end
  end

  assign int_any = rx_int | miss_seen;

  assert_flags_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!rx_int && !int_any));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_int && run) |=> rx_int);

endmodule

// File: rtl/rxr_engine.sv
module rxr_engine #(
  parameter int RING       = 16,
  parameter int SLOT_BYTES = 1544,
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  localparam int IDX_W     = $clog2(RING)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_first,
  input  logic              in_last,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic [IDX_W-1:0]  rx_ptr,
  output logic              rx_int,
  output logic              int_any,
  output logic              miss_pulse
);

  import rxr_pkg::*;

  rx_state_t        st_q, st_d;
  logic [IDX_W-1:0] slot_q;
  logic [IDX_W-1:0] scan_idx;
  logic             scan_last;
  logic             take;
  logic             found_evt, miss_evt, done_evt;
  logic             scan_clr, scan_step;
  logic             fill_clr, fill_room, fill_ovf;
  logic [CNT_W-1:0] fill_count;
  logic [15:0]      fill_len;
  logic             req_raw;

  rxr_ring_idx #(.RING(RING)) u_idx (
    .clk(clk), .rst_n(rst_n), .scan_clr(scan_clr), .scan_step(scan_step),
    .advance(done_evt), .rx_ptr(rx_ptr), .scan_idx(scan_idx), .scan_last(scan_last)
  );

  rxr_fill #(.CNT_W(CNT_W), .SLOT_BYTES(SLOT_BYTES)) u_fill (
    .clk(clk), .rst_n(rst_n), .clr(fill_clr), .take(take && st_q == ST_RECV),
    .count(fill_count), .room(fill_room), .ovf(fill_ovf), .len(fill_len)
  );

  rxr_flags u_flags (
    .clk(clk), .rst_n(rst_n), .run(run), .done(done_evt), .miss(miss_evt),
    .rx_int(rx_int), .int_any(int_any)
  );

  // handshake: a first byte in idle waits for the scan
  always_comb begin
    case (st_q)
      ST_IDLE:          in_ready = run && !in_first;
      ST_RECV, ST_DROP: in_ready = run;
      default:          in_ready = 1'b0;
    endcase
  end
  assign take = in_valid && in_ready;

  // named internal events
  assign found_evt = run && (st_q == ST_CHK) && (mem_rdata == STAT_OWNED);
  assign miss_evt  = run && (st_q == ST_CHK) && (mem_rdata != STAT_OWNED) && scan_last;
  assign done_evt  = run && (st_q == ST_WST);
  assign scan_clr  = (st_q == ST_IDLE);
  assign scan_step = run && (st_q == ST_CHK) && !found_evt && !scan_last;
  assign fill_clr  = found_evt;

  always_comb begin
    st_d = st_q;
    if (!run) st_d = ST_IDLE;
    else begin
      case (st_q)
        ST_IDLE: if (in_valid && in_first) st_d = ST_RD;
        ST_RD:   st_d = ST_CHK;
        ST_CHK:  begin
          if (found_evt) st_d = ST_RECV;
          else if (scan_last) st_d = ST_DROP;
          else st_d = ST_RD;
        end
        ST_RECV: if (take && in_last) st_d = ST_WLH;
        ST_DROP: if (take && in_last) st_d = ST_IDLE;
        ST_WLH:  st_d = ST_WLL;
        ST_WLL:  st_d = ST_WST;
        ST_WST:  st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      slot_q     <= '0;
      miss_pulse <= 1'b0;
    end else begin
      st_q       <= st_d;
      miss_pulse <= miss_evt;
      if (found_evt) slot_q <= scan_idx;
    end
  end

  // memory port
  always_comb begin
    req_raw   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st_q)
      ST_RD: begin
        req_raw  = 1'b1;
        mem_addr = ADDR_W'(desc_byte(32'(ring_base), 32'(scan_idx), OFF_STAT));
      end
      ST_RECV: begin
        req_raw   = take && fill_room;
        mem_we    = 1'b1;
        mem_addr  = ADDR_W'(buf_byte(32'(ring_base), RING, SLOT_BYTES, 32'(slot_q),
                                     32'(fill_count)));
        mem_wdata = in_data;
      end
      ST_WLH: begin
        req_raw   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ADDR_W'(desc_byte(32'(ring_base), 32'(slot_q), OFF_LEN_HI));
        mem_wdata = fill_len[15:8];
      end
      ST_WLL: begin
        req_raw   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ADDR_W'(desc_byte(32'(ring_base), 32'(slot_q), OFF_LEN_LO));
        mem_wdata = fill_len[7:0];
      end
      ST_WST: begin
        req_raw   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ADDR_W'(desc_byte(32'(ring_base), 32'(slot_q), OFF_STAT));
        mem_wdata = done_stat(fill_ovf);
      end
      default: ;
    endcase
  end
  assign mem_req = req_raw && run;

  assert_stop_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!in_ready && !mem_req));

  assert_wb_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run && st_q == ST_RECV && take && in_last) |=> !in_ready);

  assert_stat_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && st_q == ST_WST) |->
      (mem_wdata == 8'h03 || mem_wdata == 8'h13));

  assert_buf_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && st_q == ST_RECV) |-> (32'(fill_count) < SLOT_BYTES));

  assert_miss_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    miss_pulse |=> !miss_pulse);

  assert_drop_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DROP) |-> !mem_req);

endmodule

// File: tb/rxr_engine_bench.sv
`timescale 1ns/1ps
module rxr_engine_bench;

  localparam int RING   = 16;
  localparam int SLOT   = 40;
  localparam int ADDR_W = 16;
  localparam int BASE   = 64;
  localparam int MEMSZ  = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [ADDR_W-1:0] ring_base = ADDR_W'(BASE);
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [3:0] rx_ptr;
  logic rx_int, int_any, miss_pulse;

  logic [7:0] mem [MEMSZ];
  int wr_cnt = 0;
  int miss_cnt = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rxr_engine #(.RING(RING), .SLOT_BYTES(SLOT), .ADDR_W(ADDR_W)) u_rxr_engine (
    .clk(clk), .rst_n(rst_n), .run(run), .ring_base(ring_base),
    .in_valid(in_valid), .in_data(in_data), .in_first(in_first), .in_last(in_last),
    .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rx_ptr(rx_ptr),
    .rx_int(rx_int), .int_any(int_any), .miss_pulse(miss_pulse)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[9:0]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[9:0]];
      end
    end
    if (miss_pulse) miss_cnt <= miss_cnt + 1;
  end

  function automatic int daddr(int i, int off);
    return BASE + i * 8 + off;
  endfunction
  function automatic int baddr(int i, int n);
    return BASE + RING * 8 + i * SLOT + n;
  endfunction
  function automatic logic [7:0] pat(int i, int off);
    return 8'((i << 4) | off);
  endfunction
  function automatic logic [7:0] fbyte(logic [7:0] seed, int n);
    return 8'(seed + 8'(n * 5));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(logic [7:0] b, logic f, logic l);
    bit acc;
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_first = f; in_last = l;
    do begin
      #1 acc = in_ready;
      @(posedge clk);
      if (!acc) @(negedge clk);
    end while (!acc);
  endtask

  task automatic release_in();
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
  endtask

  task automatic send_frame(int len, logic [7:0] seed);
    for (int n = 0; n < len; n++) push(fbyte(seed, n), n == 0, n == len - 1);
    release_in();
    repeat (6) @(negedge clk);
  endtask

  // checks buffer bytes, length bytes and status of one delivered slot
  task automatic chk_slot(string req, int slot, int len, logic [7:0] seed);
    int cap;
    bit ok;
    cap = (len > SLOT) ? SLOT : len;
    ok = 1'b1;
    for (int n = 0; n < cap; n++) if (mem[baddr(slot, n)] !== fbyte(seed, n)) ok = 1'b0;
    chk({req, " R5 buffer bytes"}, 32'(ok), 32'd1);
    chk({req, " R6 length"}, {16'h0, mem[daddr(slot, 6)], mem[daddr(slot, 7)]}, 32'(cap));
    chk({req, " R7 status"}, 32'(mem[daddr(slot, 2)]), (len > SLOT) ? 32'h13 : 32'h03);
  endtask

  task automatic set_all_stat(logic [7:0] v);
    for (int i = 0; i < RING; i++) mem[daddr(i, 2)] = v;
  endtask

  initial begin
    int w0, m0;
    logic [7:0] guard;
    for (int a = 0; a < MEMSZ; a++) mem[a] = 8'h5A;
    for (int i = 0; i < RING; i++)
      for (int off = 0; off < 8; off++) mem[daddr(i, off)] = pat(i, off);
    set_all_stat(8'h80);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rx_ptr", 32'(rx_ptr), 0);
    chk("R1 rx_int", 32'(rx_int), 0);
    chk("R1 int_any", 32'(int_any), 0);
    chk("R1 miss_pulse", 32'(miss_pulse), 0);

    // R2: stopped, frame offered
    w0 = wr_cnt;
    in_valid = 1'b1; in_first = 1'b1; in_data = 8'hEE;
    #1 chk("R2 ready low when stopped (first)", 32'(in_ready), 0);
    in_first = 1'b0;
    #1 chk("R2 ready low when stopped (body)", 32'(in_ready), 0);
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    chk("R2 no writes when stopped", 32'(wr_cnt - w0), 0);
    chk("R2 ptr held when stopped", 32'(rx_ptr), 0);

    run = 1'b1;
    @(negedge clk);
    // R11: first byte in idle is held off
    in_valid = 1'b1; in_first = 1'b1; in_data = 8'h11;
    #1 chk("R11 ready low on waiting first byte", 32'(in_ready), 0);
    release_in();
    repeat (40) @(negedge clk);

    // basic frame into slot 0
    send_frame(5, 8'h10);
    chk_slot("R4 basic slot0", 0, 5, 8'h10);
    chk("R8 ptr after first frame", 32'(rx_ptr), 1);
    chk("R9 rx_int set", 32'(rx_int), 1);
    chk("R9 int_any set", 32'(int_any), 1);

    // R3: exact ownership match only
    mem[daddr(1, 2)] = 8'h81;
    mem[daddr(2, 2)] = 8'hC0;
    mem[daddr(3, 2)] = 8'h00;
    mem[daddr(4, 2)] = 8'h80;
    send_frame(33, 8'h37);
    chk_slot("R3 skip to slot4", 4, 33, 8'h37);
    chk("R3 desc1 untouched", 32'(mem[daddr(1, 2)]), 32'h81);
    chk("R3 desc2 untouched", 32'(mem[daddr(2, 2)]), 32'hC0);
    chk("R3 desc3 untouched", 32'(mem[daddr(3, 2)]), 32'h00);
    chk("R8 ptr steps by one not to slot", 32'(rx_ptr), 2);

    // R4: wrap, only desc0 owned, scan starts at 2
    set_all_stat(8'h00);
    mem[daddr(0, 2)] = 8'h80;
    send_frame(7, 8'hA1);
    chk_slot("R4 wrap to slot0", 0, 7, 8'hA1);
    chk("R8 ptr after wrap", 32'(rx_ptr), 3);

    // sweep: every slot in order from ptr 3
    set_all_stat(8'h80);
    for (int j = 0; j < RING; j++) begin
      int s;
      s = (3 + j) % RING;
      send_frame(1 + (j * 7) % SLOT, 8'(j * 13 + 1));
      chk_slot("R4 sweep", s, 1 + (j * 7) % SLOT, 8'(j * 13 + 1));
      chk("R8 sweep ptr", 32'(rx_ptr), 32'((4 + j) % RING));
    end

    // stop clears flags
    run = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 rx_int cleared", 32'(rx_int), 0);
    chk("R2 int_any cleared", 32'(int_any), 0);
    run = 1'b1;
    @(negedge clk);

    // R10: no descriptor qualifies (all 8'h03 now)
    w0 = wr_cnt; m0 = miss_cnt;
    send_frame(10, 8'h44);
    chk("R10 miss pulses once", 32'(miss_cnt - m0), 1);
    chk("R10 no writes", 32'(wr_cnt - w0), 0);
    chk("R10 ptr unchanged", 32'(rx_ptr), 3);
    chk("R10 int_any set", 32'(int_any), 1);
    chk("R10 rx_int unchanged", 32'(rx_int), 0);

    // R7: overflow into slot 5, guard byte at slot 6 start
    mem[daddr(5, 2)] = 8'h80;
    guard = mem[baddr(6, 0)];
    for (int n = 0; n < SLOT + 3; n++) push(fbyte(8'h5C, n), n == 0, n == SLOT + 2);
    @(negedge clk);
    in_valid = 1'b1; in_first = 1'b0; in_last = 1'b0;
    #1 chk("R11 ready low in write-back", 32'(in_ready), 0);
    in_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk_slot("R7 overflow slot5", 5, SLOT + 3, 8'h5C);
    chk("R7 no write past slot", 32'(mem[baddr(6, 0)]), 32'(guard));
    chk("R8 ptr after overflow", 32'(rx_ptr), 4);
    chk("R9 rx_int after overflow", 32'(rx_int), 1);

    // R12: other descriptor bytes intact
    begin
      bit ok;
      ok = 1'b1;
      for (int i = 0; i < RING; i++)
        for (int off = 0; off < 6; off++)
          if (off != 2 && mem[daddr(i, off)] !== pat(i, off)) ok = 1'b0;
      chk("R12 descriptor fields untouched", 32'(ok), 1);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0h expected %0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule